// File: doc/BRIEF.md
# Bus-State Sequencer for a Three-Wire Serial Card Bus

This block is the host-side sequencer of a three-wire serial card bus made of a state strobe, a bidirectional serial data line and a serial clock. Only the host starts a transfer; the card never begins one. The sequencer steps the bus through four bus states. BS0 is the interrupt/idle state, and no packet moves in it. BS1, BS2 and BS3 are the three packet phases, and together they make up one packet length. The block drives the state strobe, reports the active state to the data path, and tells the data path when the host drives the data line.

A start pulse in BS0 latches the per-state dwell length and the transfer direction. The sequencer then runs BS1, BS2, BS3 and returns to BS0. Each state lasts the dwell length, counted in serial-clock ticks supplied by the data path. In BS1 the host drives the line with the command. For a write, BS2 carries host data and BS3 is the card's handshake. For a read, BS2 is the handshake and BS3 carries card data.

If the data path flags a packet error during BS1 to BS3, the sequencer drops to BS0 and enters two-state mode. In that mode it loops BS0 and BS1 on its own, so that the host never drives the line against the card. A mode output reports this fallback. Four-state operation resumes only when the host issues a new start in BS0 with the error flag cleared.

States: BS0 (code 0, interrupt/idle), BS1 (code 1, command), BS2 (code 2, first data/handshake), BS3 (code 3, second data/handshake). Transitions:
- BS0 to BS1 on an accepted start, or on dwell expiry in two-state mode.
- BS1 to BS2, then BS2 to BS3, on dwell expiry in four-state mode.
- BS3 to BS0 on dwell expiry.
- BS1 to BS0 on dwell expiry in two-state mode.
- BS1, BS2 or BS3 to BS0 on a packet error in four-state mode.

Top module: `bus_state_seq`

## Requirements
- R1: After reset, phase is 0 (BS0), the strobe is low, the data line is released, busy is low and two_state is low.
- R2: A start pulse is accepted in BS0, except in two-state mode while pkt_err is high. On acceptance the phase becomes 1 on the next cycle, and len and cmd_write are latched, with a len of 0 taken as 1. A start in BS1, BS2 or BS3 is ignored.
- R3: In four-state mode the phase runs 1, 2, 3 and then 0. Each of BS1, BS2 and BS3 lasts exactly the latched length counted in sclk_tick pulses. The state changes on the clock edge that samples the last tick.
- R4: bs_strobe is high in BS1 and BS3 and low in BS2 and BS0.
- R5: sdio_drive is high in BS1, and in BS2 when the latched cmd_write is 1. It is low in BS0, in BS3, and in BS2 of a read (cmd_write 0).
- R6: busy is high exactly while phase is not 0, that is from the cycle after an accepted start until the return to BS0.
- R7: pkt_err high at a clock edge in BS1, BS2 or BS3 in four-state mode puts the sequencer in BS0 with two_state high on the next cycle, whatever sclk_tick does. The dwell count restarts.
- R8: In two-state mode the sequencer alternates BS0 and BS1 without a start, each lasting the latched length in ticks. It never enters BS2 or BS3, and pkt_err has no effect on it.
- R9: In two-state mode a start in BS0 with pkt_err low clears two_state and enters BS1. A start with pkt_err high, or a start in BS1, leaves the phase and two_state unchanged.
- R10: In four-state mode BS0 holds with no start, and sclk_tick has no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Host request to begin a packet |
| cmd_write | input | 1 | 1 = write packet, 0 = read packet; latched at start |
| len | input | LEN_W | Dwell per state in serial-clock ticks; latched at start, 0 treated as 1 |
| sclk_tick | input | 1 | One-cycle pulse per serial-clock period from the data path |
| pkt_err | input | 1 | Packet error flag from the data path |
| bs_strobe | output | 1 | Bus-state strobe line |
| phase | output | 2 | Current bus state, 0 to 3 for BS0 to BS3 |
| sdio_drive | output | 1 | 1 = host drives the data line |
| busy | output | 1 | Packet or fallback loop in progress |
| two_state | output | 1 | Two-state fallback mode active |

## Verification
The bound checker checks on every cycle the properties that depend only on the current state. These are the strobe level per state, a released line in BS0 and a driven line in BS1, busy against phase, confinement to BS0 and BS1 in two-state mode, and the BS2 successors. It also checks the one-cycle fallback on a packet error and the idle hold of BS0. Dwell lengths counted in ticks, the zero-length case, the direction taken from the latched write flag, and the rules for leaving fallback can only be shown by the bench's scenarios. These run over a sweep of lengths, tick spacings and directions, plus error injection in each packet phase.

// File: rtl/bss_pkg.sv
package bss_pkg;
    typedef enum logic [1:0] {
        BS_INT = 2'd0,
        BS_CMD = 2'd1,
        BS_MID = 2'd2,
        BS_END = 2'd3
    } bus_state_e;
endpackage

// File: rtl/bss_dwell_timer.sv
module bss_dwell_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             clear,
    input  logic             adv,
    output logic             last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= ONE;
        end else if (load) begin
            len_q <= (len_in == '0) ? ONE : len_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= last ? '0 : cnt_q + ONE;
        end
    end

    assign last = (cnt_q == len_q - ONE);
endmodule

// File: rtl/bss_state_fsm.sv
module bss_state_fsm
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmd_write,
    input  logic       sclk_tick,
    input  logic       pkt_err,
    input  logic       last,
    output bus_state_e state,
    output logic       two_mode,
    output logic       wr_mode,
    output logic       load,
    output logic       clear,
    output logic       adv
);
    bus_state_e state_d;
    logic       two_d;
    logic       wr_d;
    logic       run;

    always_comb begin
        state_d = state;
        two_d   = two_mode;
        wr_d    = wr_mode;
        load    = 1'b0;
        clear   = 1'b0;
        run     = 1'b0;
        unique case (state)
            BS_INT: begin
                if (start && !(two_mode && pkt_err)) begin
                    state_d = BS_CMD;
                    two_d   = 1'b0;
                    wr_d    = cmd_write;
                    load    = 1'b1;
                    clear   = 1'b1;
                end else if (two_mode) begin
                    run = 1'b1;
                    if (sclk_tick && last) state_d = BS_CMD;
                end
            end
            BS_CMD: begin
                if (!two_mode && pkt_err) begin
                    state_d = BS_INT;
                    two_d   = 1'b1;
                    clear   = 1'b1;
                end else begin
                    run = 1'b1;
                    if (sclk_tick && last) state_d = two_mode ? BS_INT : BS_MID;
                end
            end
            BS_MID: begin
                if (pkt_err) begin
                    state_d = BS_INT;
                    two_d   = 1'b1;
                    clear   = 1'b1;
                end else begin
                    run = 1'b1;
                    if (sclk_tick && last) state_d = BS_END;
                end
            end
            BS_END: begin
                if (pkt_err) begin
                    state_d = BS_INT;
                    two_d   = 1'b1;
                    clear   = 1'b1;
                end else begin
                    run = 1'b1;
                    if (sclk_tick && last) state_d = BS_INT;
                end
            end
            default: state_d = BS_INT;
        endcase
    end

    assign adv = run && sclk_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= BS_INT;
            two_mode <= 1'b0;
            wr_mode  <= 1'b0;
        end else begin
            state    <= state_d;
            two_mode <= two_d;
            wr_mode  <= wr_d;
        end
    end
endmodule

// File: rtl/bss_out_decode.sv
module bss_out_decode
    import bss_pkg::*;
(
    input  bus_state_e  state,
    input  logic        two_mode,
    input  logic        wr_mode,
    output logic        bs_strobe,
    output logic [1:0]  phase,
    output logic        sdio_drive,
    output logic        busy,
    output logic        two_state
);
    always_comb begin
        phase      = state;
        two_state  = two_mode;
        bs_strobe  = 1'b0;
        sdio_drive = 1'b0;
        busy       = 1'b1;
        unique case (state)
            BS_INT: busy = 1'b0;
            BS_CMD: begin
                bs_strobe  = 1'b1;
                sdio_drive = 1'b1;
            end
            BS_MID: sdio_drive = wr_mode;
            BS_END: bs_strobe = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_state_seq.sv
module bus_state_seq
    import bss_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_write,
    input  logic [LEN_W-1:0] len,
    input  logic             sclk_tick,
    input  logic             pkt_err,
    output logic             bs_strobe,
    output logic [1:0]       phase,
    output logic             sdio_drive,
    output logic             busy,
    output logic             two_state
);
    bus_state_e state;
    logic two_mode, wr_mode, load, clear, adv, last;

    bss_dwell_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .len_in(len),
        .clear(clear), .adv(adv), .last(last)
    );

    bss_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
        .sclk_tick(sclk_tick), .pkt_err(pkt_err), .last(last),
        .state(state), .two_mode(two_mode), .wr_mode(wr_mode),
        .load(load), .clear(clear), .adv(adv)
    );

    bss_out_decode u_dec (
        .state(state), .two_mode(two_mode), .wr_mode(wr_mode),
        .bs_strobe(bs_strobe), .phase(phase), .sdio_drive(sdio_drive),
        .busy(busy), .two_state(two_state)
    );
endmodule

// File: rtl/bus_state_seq_chk.sv
module bus_state_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       pkt_err,
    input logic [1:0] phase,
    input logic       bs_strobe,
    input logic       sdio_drive,
    input logic       busy,
    input logic       two_state
);
    // R4
    strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bs_strobe == (phase == 2'd1 || phase == 2'd3));

    // R5
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |-> !sdio_drive);

    // R5
    cmd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> sdio_drive);

    // R6
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (phase != 2'd0));

    // R7
    err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_state && phase != 2'd0 && pkt_err) |=> (phase == 2'd0 && two_state));

    // R8
    two_state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        two_state |-> (phase == 2'd0 || phase == 2'd1));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_state && phase == 2'd0 && !start) |=> (phase == 2'd0 && !two_state));

    // R3
    mid_successor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && !pkt_err) |=> (phase == 2'd2 || phase == 2'd3));
endmodule

bind bus_state_seq bus_state_seq_chk u_chk (.*);

// File: tb/bus_state_seq_test.sv
`timescale 1ns/1ps
module bus_state_seq_test;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [LW-1:0] len = '0;
    logic          sclk_tick = 1'b0;
    logic          pkt_err = 1'b0;
    logic          bs_strobe, sdio_drive, busy, two_state;
    logic [1:0]    phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bus_state_seq #(.LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
        .len(len), .sclk_tick(sclk_tick), .pkt_err(pkt_err),
        .bs_strobe(bs_strobe), .phase(phase), .sdio_drive(sdio_drive),
        .busy(busy), .two_state(two_state)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_all(input string req, input int ph, input bit wr, input bit two);
        chk(req, int'(phase), ph);
        chk("R4 strobe", int'(bs_strobe), (ph == 1 || ph == 3) ? 1 : 0);
        chk("R5 drive", int'(sdio_drive), (ph == 1 || (ph == 2 && wr)) ? 1 : 0);
        chk("R6 busy", int'(busy), (ph != 0) ? 1 : 0);
        chk({req, " mode"}, int'(two_state), int'(two));
    endtask

    // called at a negative edge; applies inputs for one rising edge
    task automatic cyc(input bit t, input bit s, input bit e);
        sclk_tick = t; start = s; pkt_err = e;
        @(posedge clk);
        @(negedge clk);
        sclk_tick = 1'b0; start = 1'b0; pkt_err = 1'b0;
    endtask

    function automatic int four_ph(input int n, input int l);
        int seg;
        seg = n / l;
        return (seg >= 3) ? 0 : seg + 1;
    endfunction

    task automatic run_packet(input int l, input int p, input bit wr);
        int leff, n;
        leff = (l == 0) ? 1 : l;
        len = LW'(l);
        cmd_write = wr;
        cyc(1'b0, 1'b1, 1'b0);
        expect_all("R2 start", 1, wr, 1'b0);
        len = '0;
        cmd_write = ~wr;
        n = 0;
        for (int k = 0; n < 3 * leff; k++) begin
            bit t;
            t = ((k % p) == p - 1);
            cyc(t, !t, 1'b0);
            if (t) n++;
            expect_all(t ? "R3 dwell" : "R2 start-ignored", four_ph(n, leff), wr, 1'b0);
        end
        cyc(1'b1, 1'b0, 1'b0);
        expect_all("R10 idle", 0, wr, 1'b0);
    endtask

    task automatic run_error(input int l, input int ep, input bit wr);
        int n;
        len = LW'(l);
        cmd_write = wr;
        cyc(1'b0, 1'b1, 1'b0);
        for (int k = 0; k < (ep - 1) * l; k++) cyc(1'b1, 1'b0, 1'b0);
        expect_all("R3 pre-error", ep, wr, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        expect_all("R7 fallback", 0, wr, 1'b1);
        n = 0;
        for (int k = 0; k < 4 * l; k++) begin
            cyc(1'b1, 1'b0, bit'(k % 2));
            n++;
            expect_all("R8 loop", (n / l) % 2, wr, 1'b1);
        end
        cyc(1'b0, 1'b1, 1'b1);
        expect_all("R9 start-with-error", 0, wr, 1'b1);
        for (int k = 0; k < l; k++) cyc(1'b1, 1'b0, 1'b0);
        expect_all("R8 auto-bs1", 1, wr, 1'b1);
        cyc(1'b0, 1'b1, 1'b0);
        expect_all("R9 start-in-bs1", 1, wr, 1'b1);
        for (int k = 0; k < l; k++) cyc(1'b1, 1'b0, 1'b0);
        expect_all("R8 auto-bs0", 0, wr, 1'b1);
        cyc(1'b0, 1'b1, 1'b0);
        expect_all("R9 recover", 1, wr, 1'b0);
        for (int k = 0; k < 3 * l; k++) cyc(1'b1, 1'b0, 1'b0);
        expect_all("R3 after-recover", 0, wr, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_all("R1 reset", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1 post-reset", 0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b0, 1'b1);
            expect_all("R10 tick-in-idle", 0, 1'b0, 1'b0);
        end
        for (int l = 0; l <= 5; l++)
            for (int p = 1; p <= 3; p++)
                for (int w = 0; w < 2; w++)
                    run_packet(l, p, bit'(w));
        for (int l = 1; l <= 3; l++)
            for (int ep = 1; ep <= 3; ep++)
                for (int w = 0; w < 2; w++)
                    run_error(l, ep, bit'(w));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule